// File: doc/BRIEF.md
# Double-Buffered Converter Write Sequencer

This block sits on the host side of a four-channel, 8-bit parallel digital-to-analog converter that has two register stages per channel. Each channel has an input register, loaded while the write strobe is low and latched as it rises. Each channel also has an output register, which is copied from its input register as the load strobe rises. Logic inside the chip hands the block a write request through a valid/ready handshake: a channel index and an 8-bit code. The block then drives the converter's address, data and active-low strobes so that every setup, hold and pulse-width minimum is met. The minimums are parameters given in nanoseconds, and the block converts them to clock cycles with ceiling rounding.

A separate one-cycle update request asks for a load pulse that moves all four input registers into the output registers at the same moment. A request that arrives while a write is running is held pending. Its pulse starts only after the write's data hold time has elapsed. When the mode input is high at the moment a write is accepted, that write runs single-buffered: the load strobe falls together with the write strobe and is kept low for the minimum load width after the write strobe rises. The code therefore reaches the output with no separate update request, and stale data can never pass through.

Top module: `cvt_wr_seq`

## Requirements
- R1: While reset is asserted and just after it, both strobes are high, ready is high and the address and data outputs are zero.
- R2: Each write strobe low pulse lasts exactly WR_CYC = max(ceil(write-low ns / period), ceil(data-setup ns / period), 1) cycles. Address and data are valid from the cycle the strobe falls and are stable through the whole low phase.
- R3: After the write strobe rises, address and data stay unchanged for at least HOLD_CYC = max(ceil(hold ns / period), 1) cycles, and ready stays low during that time.
- R4: Ready falls in the cycle after a request is accepted. It stays low until the whole strobe sequence has ended, so it is never high while either strobe is low.
- R5: In double-buffered mode a load pulse happens only in answer to an update request and lasts exactly LD_CYC = max(ceil(load-low ns / period), 1) cycles. One pulse moves the latest code of every channel to the outputs together. Writes with no update leave the outputs unchanged.
- R6: An update request made during a write is kept pending. In double-buffered mode its load pulse falls no sooner than HOLD_CYC cycles after the write strobe rises and never overlaps a write pulse.
- R7: In single-buffered mode the load strobe falls in the same cycle as the write strobe. It rises exactly max(HOLD_CYC, LD_CYC) cycles after the write strobe rises, and the written code then appears on its channel's output.
- R8: While an update is pending, ready is low. The pending load pulse is issued before any later write is accepted, so a write queued behind the request does not reach the outputs through that pulse.
- R9: The address output equals the accepted channel index: 0 to 3 select the first to fourth channel register.
- R10: The mode input is sampled only in the cycle a write is accepted; changing it later does not alter that write's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Block can accept a write request |
| wr_chan | input | CH_W (2) | Channel index of the request |
| wr_code | input | DATA_W (8) | Code to write |
| upd_req | input | 1 | One-cycle request for a load pulse on all channels |
| single_mode | input | 1 | 1: the accepted write is followed by an automatic load |
| dac_addr | output | CH_W (2) | Converter channel select |
| dac_data | output | DATA_W (8) | Converter data bus |
| dac_wr_n | output | 1 | Converter write strobe, active low |
| dac_ld_n | output | 1 | Converter load strobe, active low |

## Verification
The bench builds the block with a 10 ns period, 30 ns write-low, 45 ns data-setup, 25 ns hold and 40 ns load-low minimums. These give a write pulse of 5 cycles, set by setup rather than by width, a 3-cycle hold, a 4-cycle load pulse and a 4-cycle single-buffered tail set by the load width rather than by the hold. With these values each phase has a distinct length, so a wrong rounding, a swapped minimum or a tail taken from the wrong parameter changes a measured width. An emulated pair of converter registers per channel shows whether queued updates, mode changes and writes left without an update reach the outputs at the right moment.

// File: rtl/cvt_wr_pkg.sv
package cvt_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WHOLD,
        ST_LOAD,
        ST_TAIL
    } seq_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cvt_dwell_timer.sv
// Loadable down-counter: a phase loaded with N-1 expires after N cycles.
module cvt_dwell_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cvt_upd_flag.sv
// Pending update flag; a request in the same cycle as a consume wins.
module cvt_upd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic consume,
    output logic pending
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (consume) pend_d = 1'b0;
        if (set_req) pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;
endmodule

// File: rtl/cvt_wr_seq.sv
module cvt_wr_seq #(
    parameter int unsigned CH_W          = 2,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_WR_LO_NS    = 50,
    parameter int unsigned T_DSU_NS      = 45,
    parameter int unsigned T_DH_NS       = 10,
    parameter int unsigned T_LD_LO_NS    = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DATA_W-1:0] wr_code,
    input  logic              upd_req,
    input  logic              single_mode,
    output logic [CH_W-1:0]   dac_addr,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_wr_n,
    output logic              dac_ld_n
);
    import cvt_wr_pkg::*;

    localparam int unsigned WR_CYC   = max_u(ns_to_cyc(T_WR_LO_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_DSU_NS, CLK_PERIOD_NS));
    localparam int unsigned HOLD_CYC = ns_to_cyc(T_DH_NS, CLK_PERIOD_NS);
    localparam int unsigned LD_CYC   = ns_to_cyc(T_LD_LO_NS, CLK_PERIOD_NS);
    localparam int unsigned TAIL_CYC = max_u(HOLD_CYC, LD_CYC);
    localparam int unsigned MAX_CYC  = max_u(WR_CYC, TAIL_CYC);
    localparam int unsigned CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        seq_state_e        st;
        logic [CH_W-1:0]   addr;
        logic [DATA_W-1:0] data;
        logic              single;
        logic              wr_n;
        logic              ld_n;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             upd_pend;
    logic             upd_take;

    cvt_dwell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    cvt_upd_flag u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (upd_req),
        .consume (upd_take),
        .pending (upd_pend)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        upd_take = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (upd_pend) begin
                    r_d.st   = ST_LOAD;
                    r_d.ld_n = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LD_CYC - 1);
                    upd_take = 1'b1;
                end else if (wr_valid) begin
                    r_d.st     = ST_WRITE;
                    r_d.addr   = wr_chan;
                    r_d.data   = wr_code;
                    r_d.single = single_mode;
                    r_d.wr_n   = 1'b0;
                    r_d.ld_n   = !single_mode;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(WR_CYC - 1);
                end
            end
            ST_WRITE: begin
                if (tmr_done) begin
                    r_d.wr_n = 1'b1;
                    tmr_load = 1'b1;
                    if (r_q.single) begin
                        r_d.st  = ST_TAIL;
                        tmr_val = CNT_W'(TAIL_CYC - 1);
                    end else begin
                        r_d.st  = ST_WHOLD;
                        tmr_val = CNT_W'(HOLD_CYC - 1);
                    end
                end
            end
            ST_WHOLD: begin
                if (tmr_done) begin
                    if (upd_pend) begin
                        r_d.st   = ST_LOAD;
                        r_d.ld_n = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(LD_CYC - 1);
                        upd_take = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_LOAD, ST_TAIL: begin
                if (tmr_done) begin
                    r_d.ld_n = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.addr   <= '0;
            r_q.data   <= '0;
            r_q.single <= 1'b0;
            r_q.wr_n   <= 1'b1;
            r_q.ld_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_ready = (r_q.st == ST_IDLE) && !upd_pend;
    assign dac_addr = r_q.addr;
    assign dac_data = r_q.data;
    assign dac_wr_n = r_q.wr_n;
    assign dac_ld_n = r_q.ld_n;
endmodule

// File: rtl/cvt_wr_seq_chk.sv
module cvt_wr_seq_chk #(
    parameter int unsigned CH_W          = 2,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_WR_LO_NS    = 50,
    parameter int unsigned T_DSU_NS      = 45,
    parameter int unsigned T_DH_NS       = 10,
    parameter int unsigned T_LD_LO_NS    = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [CH_W-1:0]   dac_addr,
    input logic [DATA_W-1:0] dac_data,
    input logic              dac_wr_n,
    input logic              dac_ld_n
);
    import cvt_wr_pkg::*;

    localparam int unsigned K_WR  = max_u(ns_to_cyc(T_WR_LO_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_DSU_NS, CLK_PERIOD_NS));
    localparam int unsigned K_H   = ns_to_cyc(T_DH_NS, CLK_PERIOD_NS);
    localparam int unsigned K_LD  = ns_to_cyc(T_LD_LO_NS, CLK_PERIOD_NS);
    localparam int unsigned K_SAT = 32'hFFFF;

    int unsigned wr_lo_q, ld_lo_q, since_q;
    logic        ovl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lo_q <= 0;
            ld_lo_q <= 0;
            since_q <= K_SAT;
            ovl_q   <= 1'b0;
        end else begin
            wr_lo_q <= dac_wr_n ? 0 : wr_lo_q + 1;
            ld_lo_q <= dac_ld_n ? 0 : ld_lo_q + 1;
            since_q <= !dac_wr_n ? 0 : ((since_q >= K_SAT) ? K_SAT : since_q + 1);
            if (!dac_ld_n && !dac_wr_n) ovl_q <= 1'b1;
            else if (dac_ld_n)          ovl_q <= 1'b0;
        end
    end

    p_wr_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_wr_n) |-> (wr_lo_q == K_WR));

    p_wr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_addr) && $stable(dac_data)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_wr_n && since_q < K_H) |-> ($stable(dac_addr) && $stable(dac_data) && !wr_ready));

    p_ready_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (dac_wr_n && dac_ld_n));

    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!dac_wr_n && !wr_ready));

    p_ld_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_ld_n) |-> (ld_lo_q >= K_LD));

    p_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dac_ld_n) && ovl_q) |-> (since_q >= K_LD && since_q >= K_H));
endmodule

bind cvt_wr_seq cvt_wr_seq_chk #(
    .CH_W(CH_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_WR_LO_NS(T_WR_LO_NS), .T_DSU_NS(T_DSU_NS), .T_DH_NS(T_DH_NS), .T_LD_LO_NS(T_LD_LO_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .dac_addr(dac_addr), .dac_data(dac_data), .dac_wr_n(dac_wr_n), .dac_ld_n(dac_ld_n)
);

// File: tb/test_cvt_wr_seq.sv
`timescale 1ns/1ps
module test_cvt_wr_seq;
    localparam int PER = 10, TWR = 30, TDSU = 45, TDH = 25, TLD = 40;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int E_WR   = (cyc(TWR) > cyc(TDSU)) ? cyc(TWR) : cyc(TDSU);
    localparam int E_H    = cyc(TDH);
    localparam int E_LD   = cyc(TLD);
    localparam int E_TAIL = (E_H > E_LD) ? E_H : E_LD;

    logic clk = 0, rst_n = 0;
    logic wr_valid = 0, upd_req = 0, single_mode = 0;
    logic [1:0] wr_chan = 0;
    logic [7:0] wr_code = 0;
    logic wr_ready, dac_wr_n, dac_ld_n;
    logic [1:0] dac_addr;
    logic [7:0] dac_data;

    always #5 clk = ~clk;

    cvt_wr_seq #(.CH_W(2), .DATA_W(8), .CLK_PERIOD_NS(PER), .T_WR_LO_NS(TWR),
                 .T_DSU_NS(TDSU), .T_DH_NS(TDH), .T_LD_LO_NS(TLD)) i_cvt_wr_seq (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_chan(wr_chan), .wr_code(wr_code), .upd_req(upd_req), .single_mode(single_mode),
        .dac_addr(dac_addr), .dac_data(dac_data), .dac_wr_n(dac_wr_n), .dac_ld_n(dac_ld_n));

    int n_chk = 0, n_fail = 0;
    bit done = 0, mon_on = 0;
    logic [7:0] exp_in [4], exp_out [4], m_in [4], m_out [4];
    logic [1:0] last_ch = 0;
    bit last_sm = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Converter register emulation and strobe timing monitor
    int wr_lo_n = 0, ld_lo_n = 0, since_rise = 1000, hold_left = 0;
    bit prev_wr = 1, prev_ld = 1, stab_bad, rdy_bad, hold_bad, ld_rdy_bad, ovl;
    logic [1:0] cap_a;
    logic [7:0] cap_d;

    always @(negedge clk) if (mon_on) begin
        if (!dac_ld_n) begin
            if (prev_ld) begin
                ld_lo_n = 0; ld_rdy_bad = 0;
                ovl = !dac_wr_n;
                if (ovl) chk(last_sm, "R7 overlap only in single mode", 0, 1);
                else     chk(since_rise >= E_H, "R6 load after hold", since_rise, E_H);
            end
            if (wr_ready) ld_rdy_bad = 1;
            ld_lo_n++;
        end else if (!prev_ld) begin
            if (ovl) chk(since_rise == E_TAIL, "R7 tail length", since_rise, E_TAIL);
            else     chk(ld_lo_n == E_LD, "R5 load width", ld_lo_n, E_LD);
            chk(!ld_rdy_bad, "R4 ready low during load", ld_rdy_bad, 0);
            for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
        end
        if (!dac_wr_n) begin
            if (prev_wr) begin
                cap_a = dac_addr; cap_d = dac_data; wr_lo_n = 0; stab_bad = 0; rdy_bad = 0;
                chk(dac_addr == last_ch, "R9 address", dac_addr, last_ch);
            end else if (dac_addr != cap_a || dac_data != cap_d) stab_bad = 1;
            if (wr_ready) rdy_bad = 1;
            wr_lo_n++;
        end else if (!prev_wr) begin
            chk(wr_lo_n == E_WR, "R2 write width", wr_lo_n, E_WR);
            chk(!stab_bad, "R2 stable during write", stab_bad, 0);
            chk(!rdy_bad, "R4 ready low during write", rdy_bad, 0);
            m_in[cap_a] = cap_d;
            since_rise = 0; hold_left = E_H; hold_bad = 0;
        end
        if (dac_wr_n) begin
            if (since_rise < 1000) since_rise++;
            if (hold_left > 0) begin
                if (dac_addr != cap_a || dac_data != cap_d || wr_ready) hold_bad = 1;
                hold_left--;
                if (hold_left == 0) chk(!hold_bad, "R3 hold", hold_bad, 0);
            end
        end
        prev_wr = dac_wr_n; prev_ld = dac_ld_n;
    end

    task automatic send(input logic [1:0] ch, input logic [7:0] code, input bit sm);
        @(negedge clk);
        wr_valid = 1; wr_chan = ch; wr_code = code; single_mode = sm;
        last_ch = ch; last_sm = sm;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 0; wr_code = ~code;
        single_mode = !sm;               // R10: later change must not matter
        exp_in[ch] = code;
        if (sm) for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
    endtask

    task automatic pulse_upd();
        @(negedge clk); upd_req = 1;
        @(negedge clk); upd_req = 0;
        for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
    endtask

    task automatic settle_and_compare(input string tag);
        @(negedge clk);
        while (!(wr_ready && dac_wr_n && dac_ld_n)) @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            chk(m_out[i] == exp_out[i], tag, m_out[i], exp_out[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7411));
        for (int i = 0; i < 4; i++) begin
            exp_in[i] = 0; exp_out[i] = 0; m_in[i] = 0; m_out[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state, during and after reset
        chk(dac_wr_n && dac_ld_n, "R1 strobes in reset", {dac_wr_n, dac_ld_n}, 3);
        rst_n = 1;
        @(negedge clk);
        mon_on = 1;
        chk(wr_ready, "R1 ready after reset", wr_ready, 1);
        chk(dac_wr_n && dac_ld_n, "R1 strobes idle", {dac_wr_n, dac_ld_n}, 3);
        chk(dac_addr == 0 && dac_data == 0, "R1 bus zero", {dac_addr, dac_data}, 0);

        // R5: double-buffered writes without update leave outputs alone
        send(0, 8'h11, 0); send(1, 8'h22, 0); send(2, 8'h33, 0); send(3, 8'hFF, 0);
        settle_and_compare("R5 no update no change");
        pulse_upd();
        settle_and_compare("R5 broadcast update");

        // R6/R8: update during write, next write queued behind it
        send(0, 8'hA5, 0);
        pulse_upd();
        send(0, 8'h5A, 0);
        settle_and_compare("R8 pending load before next write");
        pulse_upd();
        settle_and_compare("R6 queued update applied");

        // R7/R10: single-buffered write, mode flipped after acceptance
        send(2, 8'h80, 1);
        settle_and_compare("R7 single mode output R10");
        send(3, 8'h00, 0);
        settle_and_compare("R10 double after single");

        // Random mix
        for (int it = 0; it < 80; it++) begin
            logic [1:0] ch;
            logic [7:0] cd;
            bit sm;
            ch = 2'($urandom_range(0, 3));
            cd = 8'($urandom_range(0, 255));
            sm = ($urandom_range(0, 3) == 0);
            send(ch, cd, sm);
            if ($urandom_range(0, 2) == 0) pulse_upd();
            settle_and_compare("R5 R7 random outputs");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule